// File: doc/BRIEF.md
# Sprite XOR Draw Engine

This block draws an 8-pixel-wide sprite of up to 15 rows into a 64 x 32 monochrome frame buffer. The buffer lives in a 256-byte page: each row of the screen takes 8 bytes, and the most significant bit of a byte is its leftmost pixel. A start command carries an X byte, a Y byte, a row count and a sprite source address. For each row the engine reads one sprite byte from a source memory port. It then does read-modify-write cycles on the frame buffer through a second port. The sprite is XORed onto the screen, and a collision flag reports whether any lit pixel was turned off.

A sprite whose X position is not a multiple of 8 straddles two frame-buffer bytes. The engine shifts the sprite byte into a 16-bit pair and updates both bytes, testing each one for collision. A sprite is clipped at the right and bottom edges of the screen and never wraps around. All frame-buffer writes wait for a display-sync pulse on an input, so that drawing takes place during vertical blank. When the draw ends, a one-cycle done pulse is raised and the collision result is presented.

Top module: `sprite_draw_engine`

## Requirements
- R1: The byte column is X bits 5:3, the pixel offset is X bits 2:0 and the screen row is Y bits 4:0. X bits 7:6 and Y bits 7:5 have no effect. The first target byte is at frame address row*8 + column.
- R2: Each sprite byte is shifted right by the pixel offset into a 16-bit pair whose upper byte goes to the target byte. The bits shifted out go to the byte at the next address. Bit 7 is the leftmost pixel.
- R3: For every target byte, the value written is old XOR new. A collision is recorded when old AND new is nonzero. The write goes to the address just read, in the cycle after the read.
- R4: When the byte column is 7, the byte to the right is neither read nor written, so pixels beyond the right edge are discarded.
- R5: The target address steps by 8 after each row. When this step carries out of the 8-bit page, the remaining rows are dropped, so at most 32 - row rows are drawn.
- R6: No frame-buffer read or write happens before `vsync` has been sampled high at a clock edge after the start.
- R7: When `done` is high, `collision` is 1 if any byte of the draw collided and 0 otherwise. The value holds until the next accepted start.
- R8: A start with a row count of 0 makes no memory access. `done` is raised in the next cycle, with `collision` at 0.
- R9: `done` is high for exactly one cycle per accepted start. `busy` is high from the cycle after the start until and including the `done` cycle.
- R10: A start request while `busy` is high is ignored, and the running draw completes with its original parameters.
- R11: Sprite row i is read from source address src_addr + i, with one cycle of read latency on both ports. After reset, `busy`, `done`, `collision` and all enables are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Draw request, sampled when idle |
| x_pos | input | 8 | Horizontal position byte |
| y_pos | input | 8 | Vertical position byte |
| rows | input | 4 | Number of sprite rows, 0 to 15 |
| src_addr | input | SRC_AW | Address of the first sprite byte |
| vsync | input | 1 | Display-sync pulse that releases frame writes |
| src_rd_en | output | 1 | Source read strobe |
| src_rd_addr | output | SRC_AW | Source read address |
| src_rd_data | input | 8 | Source data, valid the cycle after the strobe |
| fb_rd_en | output | 1 | Frame-buffer read strobe |
| fb_wr_en | output | 1 | Frame-buffer write strobe |
| fb_addr | output | 8 | Frame-buffer byte address for read and write |
| fb_wr_data | output | 8 | Frame-buffer write data |
| fb_rd_data | input | 8 | Frame-buffer data, valid the cycle after the read strobe |
| busy | output | 1 | Draw in progress |
| done | output | 1 | One-cycle completion pulse |
| collision | output | 1 | Collision result of the last draw |

## Verification
The hardest case to reach is a sprite at the bottom-right corner. There the right-edge discard and the bottom clip on address carry-out act in the same draw, while earlier draws have already lit pixels that must now report a collision. The stimulus walks a vector table that places sprites at column 7 and on the last rows. It also redraws and overlaps earlier sprites on the frame buffer that the bench keeps across vectors, and it gives X and Y bytes with their upper bits set. Directed tests then issue a second start while a draw is still waiting for sync, and a zero-row start.

// File: rtl/sprite_draw_pkg.sv
// Package: shared sizes and the controller state type for the sprite draw engine.
// Assumes a frame buffer of FB_ROWS rows, each ROW_BYTES bytes wide, in one page.
package sprite_draw_pkg;
    localparam int BYTE_W    = 8;
    localparam int ROW_BYTES = 8;
    localparam int FB_ROWS   = 32;
    localparam int FB_AW     = $clog2(ROW_BYTES * FB_ROWS);
    localparam int COL_W     = $clog2(ROW_BYTES);
    localparam int OFS_W     = $clog2(BYTE_W);
    localparam int ROW_W     = $clog2(FB_ROWS);
    localparam int CNT_W     = 4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SYNC,
        ST_SRC_RD,
        ST_SRC_LAT,
        ST_L_RD,
        ST_L_WR,
        ST_R_RD,
        ST_R_WR
    } draw_state_t;
endpackage

// File: rtl/sprite_pos_decode.sv
// Module: splits the X and Y bytes into byte column, pixel offset and first
// frame address. Assumes the screen is 64 pixels wide, so upper bits wrap away.
module sprite_pos_decode
    import sprite_draw_pkg::*;
(
    input  logic [BYTE_W-1:0] x_pos,
    input  logic [BYTE_W-1:0] y_pos,
    output logic [COL_W-1:0]  col,
    output logic [OFS_W-1:0]  ofs,
    output logic [FB_AW-1:0]  base
);
    logic [ROW_W-1:0] row;

    // Field extraction: column from the middle X bits, offset from the low ones.
    always_comb begin
        col  = COL_W'(x_pos >> OFS_W);
        ofs  = OFS_W'(x_pos);
        row  = ROW_W'(y_pos);
        base = FB_AW'({row, col});
    end
endmodule

// File: rtl/sprite_row_shifter.sv
// Module: places one sprite byte at a pixel offset across two screen bytes.
// Assumes the MSB is the leftmost pixel; purely combinational.
module sprite_row_shifter
    import sprite_draw_pkg::*;
(
    input  logic [BYTE_W-1:0]   spr_byte,
    input  logic [OFS_W-1:0]    ofs,
    output logic [2*BYTE_W-1:0] pair
);
    // Right shift of the byte inside a double-width field.
    always_comb begin
        pair = {spr_byte, {BYTE_W{1'b0}}} >> ofs;
    end
endmodule

// File: rtl/sprite_draw_engine.sv
// Module: top of the sprite XOR draw engine. Latches a draw command and waits
// for vsync. For each sprite row it then reads the source byte and does one or
// two frame-buffer read-modify-writes. Assumes both memories have a one-cycle
// read latency and that fb_addr serves reads and writes alike.
module sprite_draw_engine
    import sprite_draw_pkg::*;
#(
    parameter int SRC_AW = 12
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic [BYTE_W-1:0]     x_pos,
    input  logic [BYTE_W-1:0]     y_pos,
    input  logic [CNT_W-1:0]      rows,
    input  logic [SRC_AW-1:0]     src_addr,
    input  logic                  vsync,
    output logic                  src_rd_en,
    output logic [SRC_AW-1:0]     src_rd_addr,
    input  logic [BYTE_W-1:0]     src_rd_data,
    output logic                  fb_rd_en,
    output logic                  fb_wr_en,
    output logic [FB_AW-1:0]      fb_addr,
    output logic [BYTE_W-1:0]     fb_wr_data,
    input  logic [BYTE_W-1:0]     fb_rd_data,
    output logic                  busy,
    output logic                  done,
    output logic                  collision
);
    localparam logic [COL_W-1:0] LAST_COL = COL_W'(ROW_BYTES - 1);

    draw_state_t state_q;
    logic                  done_q;
    logic                  coll_q;
    logic [COL_W-1:0]      col_q;
    logic [OFS_W-1:0]      ofs_q;
    logic [FB_AW-1:0]      row_addr_q;
    logic [CNT_W-1:0]      rows_q;
    logic [CNT_W-1:0]      idx_q;
    logic [SRC_AW-1:0]     src_q;
    logic [2*BYTE_W-1:0]   pair_q;

    logic [COL_W-1:0]      dec_col;
    logic [OFS_W-1:0]      dec_ofs;
    logic [FB_AW-1:0]      dec_base;
    logic [2*BYTE_W-1:0]   shf_pair;
    logic [BYTE_W-1:0]     cur_new;
    logic [FB_AW:0]        next_addr;
    logic                  last_row;

    sprite_pos_decode u_dec (
        .x_pos (x_pos),
        .y_pos (y_pos),
        .col   (dec_col),
        .ofs   (dec_ofs),
        .base  (dec_base)
    );

    sprite_row_shifter u_shf (
        .spr_byte (src_rd_data),
        .ofs      (ofs_q),
        .pair     (shf_pair)
    );

    // Row stepping: next row address with carry, and end-of-sprite detection.
    always_comb begin
        next_addr = {1'b0, row_addr_q} + (FB_AW+1)'(ROW_BYTES);
        last_row  = next_addr[FB_AW] || (idx_q == rows_q - CNT_W'(1));
        cur_new   = (state_q == ST_R_WR) ? pair_q[BYTE_W-1:0] : pair_q[2*BYTE_W-1:BYTE_W];
    end

    // Port drive: strobes and addresses decoded from the controller state.
    always_comb begin
        src_rd_en   = (state_q == ST_SRC_RD);
        src_rd_addr = src_q + SRC_AW'(idx_q);
        fb_rd_en    = (state_q == ST_L_RD) || (state_q == ST_R_RD);
        fb_wr_en    = (state_q == ST_L_WR) || (state_q == ST_R_WR);
        fb_addr     = (state_q == ST_R_RD || state_q == ST_R_WR)
                      ? row_addr_q + FB_AW'(1) : row_addr_q;
        fb_wr_data  = fb_rd_data ^ cur_new;
        busy        = (state_q != ST_IDLE) || done_q;
        done        = done_q;
        collision   = coll_q;
    end

    // Controller: command latch, sync wait, row loop and completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            done_q     <= 1'b0;
            coll_q     <= 1'b0;
            col_q      <= '0;
            ofs_q      <= '0;
            row_addr_q <= '0;
            rows_q     <= '0;
            idx_q      <= '0;
            src_q      <= '0;
            pair_q     <= '0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (start && !done_q) begin
                        col_q      <= dec_col;
                        ofs_q      <= dec_ofs;
                        row_addr_q <= dec_base;
                        rows_q     <= rows;
                        src_q      <= src_addr;
                        idx_q      <= '0;
                        coll_q     <= 1'b0;
                        if (rows == '0) begin
                            done_q <= 1'b1;
                        end else begin
                            state_q <= ST_SYNC;
                        end
                    end
                end
                ST_SYNC: begin
                    if (vsync) state_q <= ST_SRC_RD;
                end
                ST_SRC_RD: state_q <= ST_SRC_LAT;
                ST_SRC_LAT: begin
                    pair_q  <= shf_pair;
                    state_q <= ST_L_RD;
                end
                ST_L_RD: state_q <= ST_L_WR;
                ST_L_WR, ST_R_WR: begin
                    if ((fb_rd_data & cur_new) != '0) coll_q <= 1'b1;
                    if (state_q == ST_L_WR && col_q != LAST_COL) begin
                        state_q <= ST_R_RD;
                    end else begin
                        row_addr_q <= next_addr[FB_AW-1:0];
                        idx_q      <= idx_q + CNT_W'(1);
                        if (last_row) begin
                            state_q <= ST_IDLE;
                            done_q  <= 1'b1;
                        end else begin
                            state_q <= ST_SRC_RD;
                        end
                    end
                end
                ST_R_RD: state_q <= ST_R_WR;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Sync tracker for checks: set once vsync is seen while waiting, cleared when idle.
    logic sync_seen_q;
    always_ff @(posedge clk) begin
        if (!rst_n) sync_seen_q <= 1'b0;
        else if (!busy) sync_seen_q <= 1'b0;
        else if (state_q == ST_SYNC && vsync) sync_seen_q <= 1'b1;
    end

    assert_rmw_same_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
        fb_wr_en |-> $past(fb_rd_en) && fb_addr == $past(fb_addr));

    assert_no_wrap_right_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (fb_wr_en || fb_rd_en) && col_q == LAST_COL |-> fb_addr[COL_W-1:0] == LAST_COL);

    assert_write_after_sync_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (fb_wr_en || fb_rd_en) |-> sync_seen_q);

    assert_empty_draw_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && start && rows == '0 |=> done && !collision && !src_rd_en && !fb_rd_en);

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_src_in_range_R11: assert property (@(posedge clk) disable iff (!rst_n)
        src_rd_en |-> (src_rd_addr - src_q) < SRC_AW'(rows_q));
endmodule

// File: tb/tb_sprite_draw_engine.sv
module tb_sprite_draw_engine;
    localparam int SRC_AW = 12;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [7:0]        x_pos = '0;
    logic [7:0]        y_pos = '0;
    logic [3:0]        rows = '0;
    logic [SRC_AW-1:0] src_addr = '0;
    logic              vsync = 1'b0;
    logic              src_rd_en;
    logic [SRC_AW-1:0] src_rd_addr;
    logic [7:0]        src_rd_data;
    logic              fb_rd_en;
    logic              fb_wr_en;
    logic [7:0]        fb_addr;
    logic [7:0]        fb_wr_data;
    logic [7:0]        fb_rd_data;
    logic              busy;
    logic              done;
    logic              collision;

    sprite_draw_engine #(.SRC_AW(SRC_AW)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .x_pos(x_pos), .y_pos(y_pos),
        .rows(rows), .src_addr(src_addr), .vsync(vsync),
        .src_rd_en(src_rd_en), .src_rd_addr(src_rd_addr), .src_rd_data(src_rd_data),
        .fb_rd_en(fb_rd_en), .fb_wr_en(fb_wr_en), .fb_addr(fb_addr),
        .fb_wr_data(fb_wr_data), .fb_rd_data(fb_rd_data),
        .busy(busy), .done(done), .collision(collision)
    );

    always #2.5 clk = ~clk;

    logic [7:0] src_mem [256];
    logic [7:0] fb_mem  [256];
    logic [7:0] exp_fb  [256];
    logic       exp_coll;
    int         n_checks = 0;
    int         n_fail   = 0;
    int         cycles   = 0;
    int         early_acc = 0;
    int         any_acc   = 0;
    logic       sync_given = 1'b0;

    // Memory models with one-cycle read latency, plus access monitors.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (src_rd_en) src_rd_data <= src_mem[src_rd_addr[7:0]];
        if (fb_rd_en)  fb_rd_data  <= fb_mem[fb_addr];
        if (fb_wr_en)  fb_mem[fb_addr] <= fb_wr_data;
        if ((fb_rd_en || fb_wr_en) && !sync_given) early_acc <= early_acc + 1;
        if (fb_rd_en || fb_wr_en || src_rd_en) any_acc <= any_acc + 1;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        wait (cycles > 150000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=<150000", cycles);
        finish_run();
    end

    // Pixel-level reference model applied to exp_fb.
    task automatic model(input logic [7:0] x, input logic [7:0] y, input int n, input int src);
        int xo = x % 64;
        int yo = y % 32;
        exp_coll = 1'b0;
        for (int r = 0; r < n; r++) begin
            logic [7:0] b = src_mem[(src + r) % 256];
            if (yo + r >= 32) break;
            for (int k = 0; k < 8; k++) begin
                int px = xo + k;
                if (b[7-k] && px < 64) begin
                    int idx = (yo + r) * 8 + px / 8;
                    int bit_i = 7 - px % 8;
                    if (exp_fb[idx][bit_i]) exp_coll = 1'b1;
                    exp_fb[idx][bit_i] = ~exp_fb[idx][bit_i];
                end
            end
        end
    endtask

    task automatic compare_fb(input string req);
        int bad = 0;
        int first = -1;
        for (int i = 0; i < 256; i++) begin
            if (fb_mem[i] !== exp_fb[i]) begin
                bad++;
                if (first < 0) first = i;
            end
        end
        n_checks++;
        if (bad != 0) begin
            n_fail++;
            $display("FAIL %s frame byte %0d actual=%0h expected=%0h (%0d bytes differ)",
                     req, first, fb_mem[first], exp_fb[first], bad);
        end
    endtask

    // Issue one draw, optionally with a second start while busy, then check it.
    task automatic draw(input logic [7:0] x, input logic [7:0] y, input int n,
                        input int src, input bit extra_start, input string req);
        int t;
        for (int i = 0; i < 256; i++) exp_fb[i] = fb_mem[i];
        model(x, y, n, src);
        @(negedge clk);
        sync_given = 1'b0;
        x_pos = x; y_pos = y; rows = 4'(n); src_addr = SRC_AW'(src); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check({req, " R9 busy after start"}, 32'(busy), 32'd1);
        repeat (3) @(negedge clk);
        if (extra_start) begin
            x_pos = 8'h00; y_pos = 8'h00; rows = 4'd15; src_addr = 12'h000; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            repeat (2) @(negedge clk);
        end
        sync_given = 1'b1;
        vsync = 1'b1;
        @(negedge clk);
        vsync = 1'b0;
        t = 0;
        while (!done && t < 400) begin
            @(negedge clk);
            t++;
        end
        check({req, " R9 done seen"}, 32'(done), 32'd1);
        check({req, " R7 collision"}, 32'(collision), 32'(exp_coll));
        @(negedge clk);
        check({req, " R9 done one cycle"}, 32'(done), 32'd0);
        check({req, " R6 no access before sync"}, 32'(early_acc), 32'd0);
        compare_fb({req, " frame contents"});
    endtask

    // Stimulus table: {x, y, rows, src}.
    localparam logic [39:0] VEC [8] = '{
        {8'h00, 8'h00, 8'd3,  16'h0010},
        {8'h00, 8'h00, 8'd3,  16'h0010},
        {8'h0B, 8'h05, 8'd4,  16'h0020},
        {8'h3D, 8'h02, 8'd5,  16'h0030},
        {8'h10, 8'h1E, 8'd6,  16'h0040},
        {8'hC3, 8'hE1, 8'd2,  16'h0050},
        {8'h0E, 8'h07, 8'd3,  16'h0020},
        {8'h3F, 8'h1F, 8'd15, 16'h0060}
    };

    function automatic string vec_tag(input int i);
        case (i)
            0: return "R1 R2 origin";
            1: return "R3 redraw erases";
            2: return "R2 split byte";
            3: return "R4 right edge";
            4: return "R5 bottom clip";
            5: return "R1 upper bits ignored";
            6: return "R3 R7 overlap collision";
            default: return "R4 R5 R11 corner";
        endcase
    endfunction

    initial begin
        for (int i = 0; i < 256; i++) begin
            src_mem[i] = 8'(i * 29 + 131);
            fb_mem[i]  = 8'h00;
        end
        src_mem[16] = 8'hFF; src_mem[17] = 8'h81; src_mem[18] = 8'h3C;
        src_rd_data = '0;
        fb_rd_data  = '0;
        repeat (3) @(negedge clk);
        check("R11 reset busy", 32'(busy), 32'd0);
        check("R11 reset done", 32'(done), 32'd0);
        check("R11 reset collision", 32'(collision), 32'd0);
        check("R11 reset strobes", 32'({src_rd_en, fb_rd_en, fb_wr_en}), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int v = 0; v < 8; v++) begin
            draw(VEC[v][39:32], VEC[v][31:24], int'(VEC[v][23:16]),
                 int'(VEC[v][15:0]), 1'b0, vec_tag(v));
        end

        // R10: second start during the sync wait must be ignored.
        draw(8'h22, 8'h0C, 4, 16'h0070, 1'b1, "R10 start while busy");

        // R8: zero-row draw after a collision leaves collision cleared.
        begin
            int acc0;
            @(negedge clk);
            acc0 = any_acc;
            for (int i = 0; i < 256; i++) exp_fb[i] = fb_mem[i];
            x_pos = 8'h08; y_pos = 8'h03; rows = 4'd0; src_addr = 12'h010; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            check("R8 done next cycle", 32'(done), 32'd1);
            check("R8 collision zero", 32'(collision), 32'd0);
            @(negedge clk);
            check("R8 R9 done dropped", 32'(done), 32'd0);
            repeat (4) @(negedge clk);
            check("R8 no memory access", 32'(any_acc - acc0), 32'd0);
            compare_fb("R8 frame unchanged");
        end

        finish_run();
    end
endmodule